// File: doc/BRIEF.md
# Byte Shift, Rotate and Bit-Manipulation Unit

This unit performs one byte-wide shift, rotate, nibble-swap or single-bit operation on an 8-bit operand and produces the result, a result write strobe and the next value of the four condition flags. The caller provides the operand, the current flags, a 3-bit bit index and a 4-bit operation code. A separate input marks the short accumulator-only rotate form. Decode and memory access stay with the caller. The unit only computes.

Operation codes are 0 rotate left through carry, 1 rotate right through carry, 2 rotate left circular, 3 rotate right circular, 4 shift left arithmetic, 5 shift right arithmetic, 6 shift right logical, 7 nibble swap, 8 bit test, 9 bit clear and 10 bit set. Codes 11 to 15 are undefined. Flags travel as a 4-bit vector: bit 3 is Z (zero), bit 2 is N (subtract), bit 1 is H (half carry) and bit 0 is C (carry). The unit captures an operation on a clock edge where `issue` is high, and its outputs show the outcome from that edge on.

Top module: `sbu_top`

## Requirements
- R1: A rotate through carry (code 0 left, code 1 right) moves the old C into the vacated end bit (bit 0 for left, bit 7 for right), and the bit shifted out (old bit 7 for left, old bit 0 for right) becomes the new C.
- R2: A circular rotate (code 2 left, code 3 right) copies the bit shifted out into both the vacated end bit and C.
- R3: Code 4 shifts left, fills bit 0 with 0 and moves old bit 7 to C. Code 6 shifts right and fills bit 7 with 0. Code 5 shifts right and keeps bit 7 unchanged. Both right shifts move old bit 0 to C.
- R4: For codes 0 to 6 without the short form, Z is 1 exactly when the result is zero, N and H are 0, and result_we is 1.
- R5: With short_rot high, codes 0 to 3 produce the same result and C as in R1 and R2, but Z, N and H are all 0. For any other code, short_rot has no effect.
- R6: Code 7 exchanges bits 7:4 with bits 3:0. Z is set from the result, N, H and C are 0, and result_we is 1.
- R7: Code 8 sets Z to the inverse of operand bit bit_idx (0 to 7), clears N, sets H and keeps C. result_we is 0 and result shows the unchanged operand.
- R8: Code 9 clears operand bit bit_idx and code 10 sets it. Flags are unchanged and result_we is 1.
- R9: Codes 11 to 15 pass the operand to result with result_we 0 and flags unchanged.
- R10: Outputs update on the rising edge where issue is high. On an edge with issue low, result_we goes to 0 and result and flags_out hold their values.
- R11: While rst_n is low, result, result_we and flags_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Captures an operation on this edge |
| op | input | 4 | Operation code |
| short_rot | input | 1 | Short accumulator rotate form |
| bit_idx | input | 3 | Bit index for test, clear and set |
| operand | input | 8 | Source byte |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| result | output | 8 | Result byte |
| result_we | output | 1 | Result should be written |
| flags_out | output | 4 | Next flags {Z,N,H,C} |

## Verification
The checker assumes that every input is held stable and known on each edge where issue is high, because each property compares the registered outputs with $past samples of op, operand, bit_idx and flags_in. The bench changes inputs only on falling edges and raises issue for exactly one cycle per operation, then reads the outputs on the next falling edge. Idle cycles follow some operations so that the hold behaviour is seen apart from new captures.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int FLAG_W = 4;
  // flag bit positions inside the flag vector
  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;

  typedef enum logic [3:0] {
    OP_RLT  = 4'd0,
    OP_RRT  = 4'd1,
    OP_RLC  = 4'd2,
    OP_RRC  = 4'd3,
    OP_SLA  = 4'd4,
    OP_SRA  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SWAP = 4'd7,
    OP_BTST = 4'd8,
    OP_BCLR = 4'd9,
    OP_BSET = 4'd10
  } sbu_op_e;
endpackage

// File: rtl/sbu_shift_core.sv
module sbu_shift_core
  import sbu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] operand,
  input  logic         carry_in,
  output logic [W-1:0] sh_res,
  output logic         sh_carry
);
  localparam int HALF = W / 2;

  always_comb begin
    sh_res   = operand;
    sh_carry = carry_in;
    case (op)
      OP_RLT: begin
        sh_res   = {operand[W-2:0], carry_in};
        sh_carry = operand[W-1];
      end
      OP_RRT: begin
        sh_res   = {carry_in, operand[W-1:1]};
        sh_carry = operand[0];
      end
      OP_RLC: begin
        sh_res   = {operand[W-2:0], operand[W-1]};
        sh_carry = operand[W-1];
      end
      OP_RRC: begin
        sh_res   = {operand[0], operand[W-1:1]};
        sh_carry = operand[0];
      end
      OP_SLA: begin
        sh_res   = {operand[W-2:0], 1'b0};
        sh_carry = operand[W-1];
      end
      OP_SRA: begin
        sh_res   = {operand[W-1], operand[W-1:1]};
        sh_carry = operand[0];
      end
      OP_SRL: begin
        sh_res   = {1'b0, operand[W-1:1]};
        sh_carry = operand[0];
      end
      OP_SWAP: begin
        sh_res   = {operand[HALF-1:0], operand[W-1:HALF]};
        sh_carry = 1'b0;
      end
      default: begin
        sh_res   = operand;
        sh_carry = carry_in;
      end
    endcase
  end
endmodule

// File: rtl/sbu_bit_core.sv
module sbu_bit_core
  import sbu_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic [W-1:0]  operand,
  input  logic [IW-1:0] bit_idx,
  input  logic          set_mode,
  output logic [W-1:0]  bit_res,
  output logic          bit_val
);
  logic [W-1:0] sel_mask;

  for (genvar i = 0; i < W; i++) begin : g_dec
    assign sel_mask[i] = (bit_idx == IW'(i));
  end

  assign bit_val = |(operand & sel_mask);
  assign bit_res = set_mode ? (operand | sel_mask) : (operand & ~sel_mask);
endmodule

// File: rtl/sbu_flag_sel.sv
module sbu_flag_sel
  import sbu_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int FW = FLAG_W
) (
  input  logic [3:0]    op,
  input  logic          short_rot,
  input  logic [W-1:0]  operand,
  input  logic [FW-1:0] flags_in,
  input  logic [W-1:0]  sh_res,
  input  logic          sh_carry,
  input  logic [W-1:0]  bit_res,
  input  logic          bit_val,
  output logic [W-1:0]  res_n,
  output logic          we_n,
  output logic [FW-1:0] flags_n
);
  logic is_rot;
  logic sh_zero;

  assign is_rot  = (op <= 4'(OP_RRC));
  assign sh_zero = (sh_res == '0);

  always_comb begin
    res_n   = operand;
    we_n    = 1'b0;
    flags_n = flags_in;
    case (op)
      OP_RLT, OP_RRT, OP_RLC, OP_RRC, OP_SLA, OP_SRA, OP_SRL, OP_SWAP: begin
        res_n       = sh_res;
        we_n        = 1'b1;
        flags_n     = '0;
        flags_n[FZ] = (short_rot && is_rot) ? 1'b0 : sh_zero;
        flags_n[FC] = sh_carry;
      end
      OP_BTST: begin
        flags_n[FZ] = ~bit_val;
        flags_n[FN] = 1'b0;
        flags_n[FH] = 1'b1;
      end
      OP_BCLR, OP_BSET: begin
        res_n = bit_res;
        we_n  = 1'b1;
      end
      default: begin
        res_n   = operand;
        we_n    = 1'b0;
        flags_n = flags_in;
      end
    endcase
  end
endmodule

// File: rtl/sbu_top.sv
module sbu_top
  import sbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [3:0]        op,
  input  logic              short_rot,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] operand,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic [FLAG_W-1:0] flags_out
);
  logic [DATA_W-1:0] sh_res, bit_res, res_n;
  logic              sh_carry, bit_val, we_n;
  logic [FLAG_W-1:0] flags_n;
  logic [DATA_W-1:0] res_q;
  logic              we_q;
  logic [FLAG_W-1:0] flags_q;

  sbu_shift_core #(.W(DATA_W)) u_shift (
    .op       (op),
    .operand  (operand),
    .carry_in (flags_in[FC]),
    .sh_res   (sh_res),
    .sh_carry (sh_carry)
  );

  sbu_bit_core #(.W(DATA_W), .IW(IDX_W)) u_bit (
    .operand  (operand),
    .bit_idx  (bit_idx),
    .set_mode (op == 4'(OP_BSET)),
    .bit_res  (bit_res),
    .bit_val  (bit_val)
  );

  sbu_flag_sel #(.W(DATA_W), .FW(FLAG_W)) u_sel (
    .op        (op),
    .short_rot (short_rot),
    .operand   (operand),
    .flags_in  (flags_in),
    .sh_res    (sh_res),
    .sh_carry  (sh_carry),
    .bit_res   (bit_res),
    .bit_val   (bit_val),
    .res_n     (res_n),
    .we_n      (we_n),
    .flags_n   (flags_n)
  );

  // strobe register: cleared on idle cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= issue & we_n;
  end

  // data and flag registers: clock-enabled by issue
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      flags_q <= '0;
    end else if (issue) begin
      res_q   <= res_n;
      flags_q <= flags_n;
    end
  end

  assign result    = res_q;
  assign result_we = we_q;
  assign flags_out = flags_q;
endmodule

// File: rtl/sbu_chk.sv
module sbu_chk
  import sbu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              issue,
  input logic [3:0]        op,
  input logic              short_rot,
  input logic [IDX_W-1:0]  bit_idx,
  input logic [DATA_W-1:0] operand,
  input logic [FLAG_W-1:0] flags_in,
  input logic [DATA_W-1:0] result,
  input logic              result_we,
  input logic [FLAG_W-1:0] flags_out
);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> (!result_we && $stable(result) && $stable(flags_out)));

  // R7
  btest_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == 4'(OP_BTST)) |=>
      (!result_we && flags_out[FZ] == !$past(operand[bit_idx]) &&
       !flags_out[FN] && flags_out[FH] && flags_out[FC] == $past(flags_in[FC])));

  // R8
  bitmod_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (op == 4'(OP_BCLR) || op == 4'(OP_BSET))) |=>
      (result_we && flags_out == $past(flags_in)));

  // R5
  short_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && short_rot && op <= 4'(OP_RRC)) |=>
      (result_we && flags_out[FZ:FH] == 3'b000));

  // R6
  swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == 4'(OP_SWAP)) |=>
      (result == {$past(operand[3:0]), $past(operand[7:4])} && flags_out[FN:FC] == 3'b000));

  // R9
  undef_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op > 4'(OP_BSET)) |=>
      (!result_we && result == $past(operand) && flags_out == $past(flags_in)));

  // R11
  always_comb begin
    if (!rst_n) begin
      reset_zero_chk: assert (result == '0 && !result_we && flags_out == '0);
    end
  end
endmodule

bind sbu_top sbu_chk u_sbu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .issue     (issue),
  .op        (op),
  .short_rot (short_rot),
  .bit_idx   (bit_idx),
  .operand   (operand),
  .flags_in  (flags_in),
  .result    (result),
  .result_we (result_we),
  .flags_out (flags_out)
);

// File: tb/sbu_top_tb_top.sv
module sbu_top_tb_top;
  logic       clk;
  logic       rst_n;
  logic       issue;
  logic [3:0] op;
  logic       short_rot;
  logic [2:0] bit_idx;
  logic [7:0] operand;
  logic [3:0] flags_in;
  logic [7:0] result;
  logic       result_we;
  logic [3:0] flags_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  sbu_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .op        (op),
    .short_rot (short_rot),
    .bit_idx   (bit_idx),
    .operand   (operand),
    .flags_in  (flags_in),
    .result    (result),
    .result_we (result_we),
    .flags_out (flags_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] r, input logic w,
                       input logic [3:0] f);
    total++;
    if (result !== r || result_we !== w || flags_out !== f) begin
      bad++;
      $display("FAIL %s: got res=%h we=%b fl=%b, expected res=%h we=%b fl=%b",
               req, result, result_we, flags_out, r, w, f);
    end
  endtask

  // drive one operation on a falling edge, read outputs one cycle later
  task automatic run(input string req, input logic [3:0] o, input logic s,
                     input logic [2:0] idx, input logic [7:0] a, input logic [3:0] f,
                     input logic [7:0] er, input logic ew, input logic [3:0] ef);
    @(negedge clk);
    issue = 1'b1; op = o; short_rot = s; bit_idx = idx; operand = a; flags_in = f;
    @(negedge clk);
    issue = 1'b0;
    check(req, er, ew, ef);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; issue = 1'b0; op = '0; short_rot = 1'b0;
    bit_idx = '0; operand = '0; flags_in = '0;
    repeat (3) @(negedge clk);
    check("R11", 8'h00, 1'b0, 4'b0000);
    rst_n = 1'b1;
  endtask

  task automatic t_rot_carry;
    run("R1", 4'd0, 1'b0, 3'd0, 8'h85, 4'b0111, 8'h0B, 1'b1, 4'b0001);
    run("R1", 4'd1, 1'b0, 3'd0, 8'h01, 4'b0000, 8'h00, 1'b1, 4'b1001); // R4 zero
    run("R1", 4'd1, 1'b0, 3'd0, 8'h02, 4'b0001, 8'h81, 1'b1, 4'b0000);
  endtask

  task automatic t_rot_circ;
    run("R2", 4'd2, 1'b0, 3'd0, 8'h80, 4'b0000, 8'h01, 1'b1, 4'b0001);
    run("R2", 4'd3, 1'b0, 3'd0, 8'h01, 4'b0000, 8'h80, 1'b1, 4'b0001);
    run("R4", 4'd3, 1'b0, 3'd0, 8'h00, 4'b0001, 8'h00, 1'b1, 4'b1000);
  endtask

  task automatic t_shifts;
    run("R3", 4'd4, 1'b0, 3'd0, 8'hC1, 4'b0110, 8'h82, 1'b1, 4'b0001);
    run("R3", 4'd5, 1'b0, 3'd0, 8'h81, 4'b0000, 8'hC0, 1'b1, 4'b0001);
    run("R3", 4'd6, 1'b0, 3'd0, 8'h81, 4'b0000, 8'h40, 1'b1, 4'b0001);
    run("R4", 4'd6, 1'b0, 3'd0, 8'h01, 4'b0000, 8'h00, 1'b1, 4'b1001);
  endtask

  task automatic t_short;
    run("R5", 4'd0, 1'b1, 3'd0, 8'h80, 4'b1110, 8'h00, 1'b1, 4'b0001);
    run("R5", 4'd3, 1'b1, 3'd0, 8'h00, 4'b0001, 8'h00, 1'b1, 4'b0000);
    run("R5", 4'd7, 1'b1, 3'd0, 8'h00, 4'b0000, 8'h00, 1'b1, 4'b1000);
  endtask

  task automatic t_swap;
    run("R6", 4'd7, 1'b0, 3'd0, 8'hA5, 4'b0111, 8'h5A, 1'b1, 4'b0000);
  endtask

  task automatic t_btest;
    run("R7", 4'd8, 1'b0, 3'd3, 8'hF7, 4'b0001, 8'hF7, 1'b0, 4'b1011);
    run("R7", 4'd8, 1'b0, 3'd7, 8'h80, 4'b0000, 8'h80, 1'b0, 4'b0010);
    run("R7", 4'd8, 1'b0, 3'd0, 8'hFE, 4'b0100, 8'hFE, 1'b0, 4'b1010);
  endtask

  task automatic t_bitmod;
    run("R8", 4'd9,  1'b0, 3'd7, 8'hFF, 4'b1010, 8'h7F, 1'b1, 4'b1010);
    run("R8", 4'd10, 1'b0, 3'd0, 8'h00, 4'b0101, 8'h01, 1'b1, 4'b0101);
    run("R8", 4'd10, 1'b0, 3'd4, 8'hEF, 4'b0000, 8'hFF, 1'b1, 4'b0000);
  endtask

  task automatic t_hold;
    @(negedge clk);
    check("R10", 8'hFF, 1'b0, 4'b0000);
    operand = 8'h12; flags_in = 4'b1111; op = 4'd7;
    @(negedge clk);
    check("R10", 8'hFF, 1'b0, 4'b0000);
  endtask

  task automatic t_undef;
    run("R9", 4'd11, 1'b0, 3'd2, 8'h3C, 4'b1101, 8'h3C, 1'b0, 4'b1101);
    run("R9", 4'd15, 1'b1, 3'd5, 8'hC3, 4'b0010, 8'hC3, 1'b0, 4'b0010);
  endtask

  initial begin
    t_reset();
    t_rot_carry();
    t_rot_circ();
    t_shifts();
    t_short();
    t_swap();
    t_btest();
    t_bitmod();
    t_hold();
    t_undef();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got running, expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule